// File: doc/BRIEF.md
# Boot-Remapping System Address Decoder

This block is the first decode stage on a 32-bit system bus. It looks at the address of each transfer and picks one target: internal memory, one of six external chip selects, or the peripheral bridge. The top four address bits pick one of sixteen 256 MB banks. Bank 0 has a second decode level that works in 1 MB regions. One region holds the boot ROM and one holds the 32 KB SRAM. A third region, the low region starting at address zero, is an alias whose target depends on the boot state. Any address that no target claims returns an error to the requesting master.

What the low region shows is set by a boot-mode strap and a remap flag. The remap flag is one-way and is cleared only by reset. Before remap, the low region reaches the boot ROM when the strap is high and external chip select 0 when it is low. After remap, the low region reaches the SRAM.

All selects are combinational from the address and are gated by the transfer-valid strobe. The only state in the block is the remap flag.

Top module: `sys_addr_decoder`

## Requirements
- R1: When `xferValid` is low, `slaveSel`, `decodeErr`, `extCsIdx` and `sramOffset` are all zero. The remap flag is clear after reset.
- R2: A valid access to bank N (N = `addr[31:28]`, 1 to 6) sets `slaveSel[2]` (external bus) and sets `extCsIdx` to N-1.
- R3: A valid access to bank 15 sets `slaveSel[3]` (peripheral bridge).
- R4: A valid access to banks 7 to 14 sets `decodeErr` and sets no select.
- R5: A valid access to the 1 MB region at 0x0010_0000 sets `slaveSel[0]` (boot ROM), whatever the strap and remap state.
- R6: A valid access to the 1 MB region at 0x0030_0000 sets `slaveSel[1]` (SRAM). `sramOffset` then equals `addr[14:0]`, so the 32 KB SRAM repeats across the window.
- R7: A valid bank-0 access whose region index `addr[27:20]` is not 0, 1 or 3 sets `decodeErr`.
- R8: Before remap with `bootStrap` = 1, a valid access to region 0 of bank 0 selects the boot ROM.
- R9: Before remap with `bootStrap` = 0, a valid access to region 0 of bank 0 selects the external bus with `extCsIdx` = 0.
- R10: `remapReq` high at a rising clock edge sets the remap flag. From the next cycle on, region 0 of bank 0 selects the SRAM whatever the strap. The flag stays set until `rstN` is asserted.
- R11: Every valid transfer activates exactly one of the four `slaveSel` bits or `decodeErr`. `extCsIdx` is zero unless `slaveSel[2]` is set, and `sramOffset` is zero unless `slaveSel[1]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the remap flag |
| rstN | input | 1 | Active-low synchronous reset; clears the remap flag |
| addr | input | 32 | Transfer address |
| xferValid | input | 1 | Transfer valid strobe |
| bootStrap | input | 1 | Boot-mode strap; 1 = boot ROM at address zero before remap |
| remapReq | input | 1 | Remap command; sets the sticky remap flag |
| slaveSel | output | 4 | One-hot select: bit0 ROM, bit1 SRAM, bit2 external bus, bit3 peripheral bridge |
| extCsIdx | output | 3 | External chip-select index |
| decodeErr | output | 1 | Error response for an unmapped address |
| sramOffset | output | 15 | Byte offset into the SRAM, modulo 32 KB |

## Verification
The bench builds the block with its package defaults: sixteen banks, six external chip selects, 1 MB regions and a 15-bit SRAM offset. With these values a short directed sweep reaches every bank, the edges of the external-bank range and of the error range, and every bank-0 region class. The remap flag is exercised under both strap values, including with the request held and after a second reset.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int ADDR_W         = 32;
  localparam int BANK_W         = 4;
  localparam int REGION_W       = 20;
  localparam int EXT_CS_NUM     = 6;
  localparam int EXT_FIRST_BANK = 1;
  localparam int PERIPH_BANK    = 15;
  localparam int ROM_REGION     = 1;
  localparam int SRAM_REGION    = 3;
  localparam int SRAM_AW        = 15;

  localparam int SUBREG_W = ADDR_W - BANK_W - REGION_W;
  localparam int CS_IDX_W = $clog2(EXT_CS_NUM);

  localparam int SLV_ROM    = 0;
  localparam int SLV_SRAM   = 1;
  localparam int SLV_EXT    = 2;
  localparam int SLV_PERIPH = 3;
  localparam int SLV_NUM    = 4;

  typedef struct packed {
    logic aliasSram;
    logic aliasRom;
  } mapCtrl_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import addr_dec_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bootStrap,
  input  logic     remapReq,
  output mapCtrl_t ctl
);
  logic remapped;

  always_ff @(posedge clk) begin
    if (!rstN)         remapped <= 1'b0;
    else if (remapReq) remapped <= 1'b1;
  end

  always_comb begin
    ctl.aliasSram = remapped;
    ctl.aliasRom  = !remapped && bootStrap;
  end
endmodule

// File: rtl/addr_route_dp.sv
module addr_route_dp
  import addr_dec_pkg::*;
(
  input  logic [ADDR_W-1:0]   addr,
  input  logic                xferValid,
  input  mapCtrl_t            ctl,
  output logic [SLV_NUM-1:0]  slaveSel,
  output logic [CS_IDX_W-1:0] extCsIdx,
  output logic                decodeErr,
  output logic [SRAM_AW-1:0]  sramOffset
);
  logic [BANK_W-1:0]     bank;
  logic [SUBREG_W-1:0]   region;
  logic [EXT_CS_NUM-1:0] csHit;
  logic [CS_IDX_W-1:0]   csIdxRaw;
  logic [SLV_NUM-1:0]    rawSel;
  logic [CS_IDX_W-1:0]   rawIdx;
  logic                  rawErr;
  logic                  unusedAddr;

  assign bank       = addr[ADDR_W-1 -: BANK_W];
  assign region     = addr[ADDR_W-BANK_W-1 -: SUBREG_W];
  assign unusedAddr = ^addr[REGION_W-1:SRAM_AW];

  for (genvar g = 0; g < EXT_CS_NUM; g++) begin : g_csHit
    assign csHit[g] = (bank == BANK_W'(EXT_FIRST_BANK + g));
  end

  always_comb begin
    csIdxRaw = '0;
    for (int i = 0; i < EXT_CS_NUM; i++) begin
      if (csHit[i]) csIdxRaw = CS_IDX_W'(i);
    end
  end

  always_comb begin
    rawSel = '0;
    rawIdx = '0;
    rawErr = 1'b0;
    if (bank == '0) begin
      if (region == '0) begin
        if (ctl.aliasSram)     rawSel[SLV_SRAM] = 1'b1;
        else if (ctl.aliasRom) rawSel[SLV_ROM]  = 1'b1;
        else                   rawSel[SLV_EXT]  = 1'b1;
      end else if (region == SUBREG_W'(ROM_REGION)) begin
        rawSel[SLV_ROM] = 1'b1;
      end else if (region == SUBREG_W'(SRAM_REGION)) begin
        rawSel[SLV_SRAM] = 1'b1;
      end else begin
        rawErr = 1'b1;
      end
    end else if (|csHit) begin
      rawSel[SLV_EXT] = 1'b1;
      rawIdx          = csIdxRaw;
    end else if (bank == BANK_W'(PERIPH_BANK)) begin
      rawSel[SLV_PERIPH] = 1'b1;
    end else begin
      rawErr = 1'b1;
    end
  end

  always_comb begin
    slaveSel   = xferValid ? rawSel : '0;
    decodeErr  = xferValid && rawErr;
    extCsIdx   = slaveSel[SLV_EXT] ? rawIdx : '0;
    sramOffset = slaveSel[SLV_SRAM] ? addr[SRAM_AW-1:0] : '0;
  end
endmodule

// File: rtl/sys_addr_decoder.sv
module sys_addr_decoder
  import addr_dec_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                xferValid,
  input  logic                bootStrap,
  input  logic                remapReq,
  output logic [SLV_NUM-1:0]  slaveSel,
  output logic [CS_IDX_W-1:0] extCsIdx,
  output logic                decodeErr,
  output logic [SRAM_AW-1:0]  sramOffset
);
  mapCtrl_t ctl;

  remap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bootStrap(bootStrap),
    .remapReq (remapReq),
    .ctl      (ctl)
  );

  addr_route_dp u_dp (
    .addr      (addr),
    .xferValid (xferValid),
    .ctl       (ctl),
    .slaveSel  (slaveSel),
    .extCsIdx  (extCsIdx),
    .decodeErr (decodeErr),
    .sramOffset(sramOffset)
  );
endmodule

// File: rtl/sys_addr_decoder_chk.sv
module sys_addr_decoder_chk
  import addr_dec_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic                xferValid,
  input logic                bootStrap,
  input logic                remapReq,
  input logic [SLV_NUM-1:0]  slaveSel,
  input logic [CS_IDX_W-1:0] extCsIdx,
  input logic                decodeErr,
  input logic [SRAM_AW-1:0]  sramOffset
);
  logic seenRemap;
  logic lowWin;

  always_ff @(posedge clk) begin
    if (!rstN)         seenRemap <= 1'b0;
    else if (remapReq) seenRemap <= 1'b1;
  end

  assign lowWin = (addr[ADDR_W-1:REGION_W] == '0);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !xferValid |-> (slaveSel == '0 && !decodeErr));

  p_periph_bank_r3: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && addr[ADDR_W-1 -: BANK_W] == BANK_W'(PERIPH_BANK))
      |-> (slaveSel == 4'b1000));

  p_rom_fixed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && addr[ADDR_W-1:REGION_W] == 12'h001) |-> (slaveSel == 4'b0001));

  p_sram_alias_r6: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && addr[ADDR_W-1:REGION_W] == 12'h003)
      |-> (slaveSel == 4'b0010 && sramOffset == addr[SRAM_AW-1:0]));

  p_sticky_remap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (seenRemap && xferValid && lowWin) |-> (slaveSel == 4'b0010));

  p_boot_rom_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!seenRemap && bootStrap && xferValid && lowWin) |-> (slaveSel == 4'b0001));

  p_one_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> ($countones({slaveSel, decodeErr}) == 1));

  p_idx_gated_r11: assert property (@(posedge clk) disable iff (!rstN)
    !slaveSel[SLV_EXT] |-> (extCsIdx == '0));
endmodule

bind sys_addr_decoder sys_addr_decoder_chk u_chk (.*);

// File: tb/test_sys_addr_decoder.sv
`timescale 1ns/1ps
module test_sys_addr_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] addr = '0;
  logic        xferValid = 1'b0;
  logic        bootStrap = 1'b0;
  logic        remapReq = 1'b0;
  logic [3:0]  slaveSel;
  logic [2:0]  extCsIdx;
  logic        decodeErr;
  logic [14:0] sramOffset;

  int checks = 0;
  int fails  = 0;
  bit modelRemap = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sys_addr_decoder i_sys_addr_decoder (
    .clk(clk), .rstN(rstN), .addr(addr), .xferValid(xferValid),
    .bootStrap(bootStrap), .remapReq(remapReq), .slaveSel(slaveSel),
    .extCsIdx(extCsIdx), .decodeErr(decodeErr), .sramOffset(sramOffset)
  );

  always @(posedge clk) begin
    if (!rstN)         modelRemap <= 1'b0;
    else if (remapReq) modelRemap <= 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%0h expected=%0h", req, addr, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [31:0] a, input bit v,
                      input bit strap, input bit rq);
    int bank, region, expSel, expIdx, expErr, expOff;
    @(negedge clk);
    addr = a; xferValid = v; bootStrap = strap; remapReq = rq;
    #1;
    bank = int'(a[31:28]); region = int'(a[27:20]);
    expSel = 0; expIdx = 0; expErr = 0; expOff = 0;
    if (v) begin
      if (bank == 0) begin
        if (region == 0) begin
          if (modelRemap) expSel = 2;
          else if (strap) expSel = 1;
          else expSel = 4;
        end else if (region == 1) expSel = 1;
        else if (region == 3) expSel = 2;
        else expErr = 1;
      end else if (bank >= 1 && bank <= 6) begin
        expSel = 4; expIdx = bank - 1;
      end else if (bank == 15) expSel = 8;
      else expErr = 1;
      if (expSel == 2) expOff = int'(a[14:0]);
    end
    check({req, " sel"}, int'(slaveSel), expSel);
    check({req, " idx"}, int'(extCsIdx), expIdx);
    check({req, " err"}, int'(decodeErr), expErr);
    check({req, " off"}, int'(sramOffset), expOff);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step("R1 reset state", 32'h0000_0010, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    step("R1 idle", 32'h3000_0000, 1'b0, 1'b0, 1'b0);
    step("R1 idle err bank", 32'h9000_0000, 1'b0, 1'b0, 1'b0);
    for (int b = 1; b <= 6; b++)
      step("R2 ext bank", {b[3:0], 28'h0AB_CDE0}, 1'b1, 1'b0, 1'b0);
    step("R3 periph", 32'hF000_1234, 1'b1, 1'b0, 1'b0);
    step("R3 periph top", 32'hFFFF_FFFC, 1'b1, 1'b1, 1'b0);
    for (int b = 7; b <= 14; b++)
      step("R4 unmapped", {b[3:0], 28'h000_0040}, 1'b1, 1'b0, 1'b0);
    step("R5 rom", 32'h0010_0000, 1'b1, 1'b0, 1'b0);
    step("R5 rom end", 32'h001F_FFFF, 1'b1, 1'b1, 1'b0);
    step("R6 sram", 32'h0030_0004, 1'b1, 1'b0, 1'b0);
    step("R6 sram alias", 32'h0030_9ABC, 1'b1, 1'b0, 1'b0);
    step("R6 sram alias top", 32'h003F_FFFF, 1'b1, 1'b0, 1'b0);
    step("R7 region2", 32'h0020_0000, 1'b1, 1'b0, 1'b0);
    step("R7 region4", 32'h0040_0100, 1'b1, 1'b0, 1'b0);
    step("R7 region ff", 32'h0FF0_0000, 1'b1, 1'b1, 1'b0);
    step("R8 boot rom", 32'h0000_0000, 1'b1, 1'b1, 1'b0);
    step("R8 boot rom end", 32'h000F_FFFF, 1'b1, 1'b1, 1'b0);
    step("R9 boot ext", 32'h0000_0100, 1'b1, 1'b0, 1'b0);
    step("R10 request cycle", 32'h0000_0000, 1'b1, 1'b1, 1'b1);
    step("R10 after remap", 32'h0000_1234, 1'b1, 1'b1, 1'b0);
    step("R10 after remap strap0", 32'h000F_8001, 1'b1, 1'b0, 1'b0);
    step("R10 rom still", 32'h0010_0040, 1'b1, 1'b0, 1'b0);
    step("R10 held", 32'h0000_0008, 1'b1, 1'b0, 1'b1);
    step("R10 sticky", 32'h0000_0008, 1'b1, 1'b1, 1'b0);
    step("R11 ext after remap", 32'h6000_0000, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    step("R10 cleared by reset", 32'h0000_0000, 1'b1, 1'b0, 1'b0);
    step("R10 cleared strap1", 32'h0000_0000, 1'b1, 1'b1, 1'b0);
    step("R11 idle", 32'h0030_0000, 1'b0, 1'b1, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule